// File: doc/BRIEF.md
# ADC Scan Sequencer

This block drives a multiplexed successive-approximation converter over a three-wire, full-duplex serial link. A small scan list holds one 8-bit configuration word per entry. The sequencer walks the list in order. For each entry it shifts the configuration word out while it shifts in the result of the conversion requested one exchange earlier. It then pulses the conversion-start line and waits for the busy line to report completion.

The converter always answers one request late. The sequencer therefore keeps a one-deep history of the request whose result is in flight, and tags every delivered result with that request's configuration word and list index. A result that does not belong to a known request is dropped rather than delivered. This covers the first exchange after reset, the first after a list write, and the exchange after a timed-out conversion. Results leave on a valid/ready port that holds its contents until they are accepted.

Top module: `adc_scan_sequencer`

## Requirements
- R1: During reset and in the cycle after it, `adc_sck`, `adc_convst`, `res_valid` and `err_timeout` are all low.
- R2: Each exchange sends the selected 8-bit configuration word on `adc_sdi`, most significant bit first, one bit per SCK period. `adc_sdi` changes only while `adc_sck` is low, and it is low once the eighth bit has been sent. Bit meaning, MSB to LSB: single/differential select, odd/sign, channel select high, channel select low, unipolar, gain, nap, sleep.
- R3: Each exchange has exactly RES_W rising SCK edges. Each SCK level lasts SCK_HALF clocks. `adc_sdo` is captured on each rising edge, most significant bit first.
- R4: Each exchange is followed by exactly one `adc_convst` pulse, high for CONVST_HI clocks. SCK stays low while CONVST is high.
- R5: After a CONVST pulse, no new exchange starts until `adc_busy` has been seen low and then high again.
- R6: A delivered result carries in `res_cfg`/`res_idx` the configuration word and list index of the request sent one exchange before the one that returned it.
- R7: The result returned by the first exchange after reset is dropped. The first delivered result belongs to list entry 0.
- R8: A write to the scan list drops any result still in flight, restarts the scan at entry 0, and clears `err_timeout`. The first result delivered afterwards is entry 0 with its newly written word.
- R9: Entries are requested in order 0, 1, … `scan_last`, then the scan wraps to 0.
- R10: While `res_valid` is high and `res_ready` is low, the result port holds its contents and no new exchange starts.
- R11: If completion is not seen within `busy_limit` clocks of CONVST falling, `err_timeout` is set and stays set. The result for that request is dropped, and the scan moves on to the next entry.
- R12: While `run` is low, no new exchange starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Permits new exchanges |
| scan_last | input | IDX_W | Index of the last scan list entry |
| busy_limit | input | TMO_W | Clocks allowed for a conversion to finish |
| cfg_we | input | 1 | Scan list write strobe |
| cfg_addr | input | IDX_W | Scan list write index |
| cfg_wdata | input | 8 | Configuration word to store |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_sdi | output | 1 | Configuration data to the converter |
| adc_sdo | input | 1 | Result data from the converter |
| adc_convst | output | 1 | Conversion start pulse |
| adc_busy | input | 1 | Low while the converter is converting |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | RES_W | Conversion result |
| res_cfg | output | 8 | Configuration word that requested the result |
| res_idx | output | IDX_W | List index that requested the result |
| err_timeout | output | 1 | Sticky conversion timeout flag |

## Verification
The scan is run over a four-entry list of dissimilar words. The converter model builds each result from the bits it actually captured, so a wrong bit order, a wrong edge or an off-by-one-exchange tag each change `res_data` or `res_cfg`. Holding `res_ready` low separates a correct stall from a port that drifts or keeps converting. A list write in mid-scan, a converter that never signals busy, and a dropped `run` show whether the stale result is discarded, the restart lands on entry 0, and the error flag sticks until the list is written.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CFG_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_XFER = 2'd1,
        SEQ_CONV = 2'd2,
        SEQ_WAIT = 2'd3
    } seq_state_e;
endpackage

// File: rtl/adc_seq_list.sv
module adc_seq_list #(
    parameter int DEPTH = 8,
    parameter int CFG_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CFG_W-1:0] rd_data
);
    logic [CFG_W-1:0] entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [CFG_W-1:0] entry_d;

        always_comb begin
            entry_d = entry_q[g];
            if (wr_en && wr_addr == IDX_W'(g)) entry_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) entry_q[g] <= '0;
            else        entry_q[g] <= entry_d;
        end
    end

    assign rd_data = entry_q[rd_addr];
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int RES_W    = 12,
    parameter int SCK_HALF = 2,
    parameter int CFG_W    = 8,
    localparam int HC_W    = $clog2(SCK_HALF + 1),
    localparam int EC_W    = $clog2(RES_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic             sdo_in,
    output logic             sck,
    output logic             sdi,
    output logic             done,
    output logic [RES_W-1:0] result
);
    typedef struct packed {
        logic             active;
        logic             sck;
        logic             done;
        logic [HC_W-1:0]  half;
        logic [EC_W-1:0]  rises;
        logic [CFG_W-1:0] tx;
        logic [RES_W-1:0] rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.active) begin
            if (start) begin
                sh_d.active = 1'b1;
                sh_d.sck    = 1'b0;
                sh_d.half   = '0;
                sh_d.rises  = '0;
                sh_d.tx     = cfg_in;
            end
        end else if (sh_q.half == HC_W'(SCK_HALF - 1)) begin
            sh_d.half = '0;
            if (!sh_q.sck) begin
                sh_d.sck   = 1'b1;
                sh_d.rx    = {sh_q.rx[RES_W-2:0], sdo_in};
                sh_d.rises = sh_q.rises + 1'b1;
            end else begin
                sh_d.sck = 1'b0;
                sh_d.tx  = {sh_q.tx[CFG_W-2:0], 1'b0};
                if (sh_q.rises == EC_W'(RES_W)) begin
                    sh_d.active = 1'b0;
                    sh_d.done   = 1'b1;
                    sh_d.tx     = '0;
                end
            end
        end else begin
            sh_d.half = sh_q.half + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck    = sh_q.sck;
    assign sdi    = sh_q.tx[CFG_W-1];
    assign done   = sh_q.done;
    assign result = sh_q.rx;
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int DEPTH      = 8,
    parameter int SCK_HALF   = 2,
    parameter int CONVST_HI  = 2,
    parameter int TMO_W      = 16,
    localparam int IDX_W     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [IDX_W-1:0] scan_last,
    input  logic [TMO_W-1:0] busy_limit,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic             adc_sck,
    output logic             adc_sdi,
    input  logic             adc_sdo,
    output logic             adc_convst,
    input  logic             adc_busy,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [RES_W-1:0] res_data,
    output logic [7:0]       res_cfg,
    output logic [IDX_W-1:0] res_idx,
    output logic             err_timeout
);
    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] req_idx;
        logic [IDX_W-1:0] prev_idx;
        logic [IDX_W-1:0] out_idx;
        logic [CFG_W-1:0] req_cfg;
        logic [CFG_W-1:0] prev_cfg;
        logic [CFG_W-1:0] out_cfg;
        logic [RES_W-1:0] out_data;
        logic [TMO_W-1:0] cnt;
        logic             prev_ok;
        logic             restart;
        logic             out_valid;
        logic             err;
        logic             convst;
        logic             seen_low;
        logic             busy_s1;
        logic             busy_s2;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic [CFG_W-1:0] list_rd;
    logic             sh_start;
    logic             sh_done;
    logic [RES_W-1:0] sh_result;
    logic [IDX_W-1:0] idx_next;

    adc_seq_list #(.DEPTH(DEPTH), .CFG_W(CFG_W)) u_list (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .rd_addr (c_q.idx),
        .rd_data (list_rd)
    );

    adc_seq_shift #(.RES_W(RES_W), .SCK_HALF(SCK_HALF), .CFG_W(CFG_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sh_start),
        .cfg_in (list_rd),
        .sdo_in (adc_sdo),
        .sck    (adc_sck),
        .sdi    (adc_sdi),
        .done   (sh_done),
        .result (sh_result)
    );

    assign idx_next = (c_q.idx == scan_last) ? '0 : c_q.idx + 1'b1;

    always_comb begin
        c_d         = c_q;
        sh_start    = 1'b0;
        c_d.busy_s1 = adc_busy;
        c_d.busy_s2 = c_q.busy_s1;

        if (c_q.out_valid && res_ready) c_d.out_valid = 1'b0;

        unique case (c_q.st)
            SEQ_IDLE: begin
                if (c_q.restart) begin
                    c_d.idx     = '0;
                    c_d.prev_ok = 1'b0;
                    c_d.restart = 1'b0;
                end else if (run && !c_q.out_valid) begin
                    sh_start    = 1'b1;
                    c_d.req_cfg = list_rd;
                    c_d.req_idx = c_q.idx;
                    c_d.st      = SEQ_XFER;
                end
            end
            SEQ_XFER: begin
                if (sh_done) begin
                    if (c_q.prev_ok && !cfg_we) begin
                        c_d.out_valid = 1'b1;
                        c_d.out_data  = sh_result;
                        c_d.out_cfg   = c_q.prev_cfg;
                        c_d.out_idx   = c_q.prev_idx;
                    end
                    c_d.prev_ok = 1'b0;
                    c_d.convst  = 1'b1;
                    c_d.cnt     = '0;
                    c_d.st      = SEQ_CONV;
                end
            end
            SEQ_CONV: begin
                if (c_q.cnt == TMO_W'(CONVST_HI - 1)) begin
                    c_d.convst   = 1'b0;
                    c_d.cnt      = '0;
                    c_d.seen_low = 1'b0;
                    c_d.st       = SEQ_WAIT;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            SEQ_WAIT: begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (!c_q.busy_s2) c_d.seen_low = 1'b1;
                if (c_q.seen_low && c_q.busy_s2) begin
                    c_d.prev_cfg = c_q.req_cfg;
                    c_d.prev_idx = c_q.req_idx;
                    c_d.prev_ok  = !c_q.restart && !cfg_we;
                    c_d.idx      = idx_next;
                    c_d.st       = SEQ_IDLE;
                end else if (c_q.cnt >= busy_limit) begin
                    c_d.err     = 1'b1;
                    c_d.prev_ok = 1'b0;
                    c_d.idx     = idx_next;
                    c_d.st      = SEQ_IDLE;
                end
            end
            default: c_d.st = SEQ_IDLE;
        endcase

        if (cfg_we) begin
            c_d.restart = 1'b1;
            c_d.prev_ok = 1'b0;
            c_d.err     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign adc_convst  = c_q.convst;
    assign res_valid   = c_q.out_valid;
    assign res_data    = c_q.out_data;
    assign res_cfg     = c_q.out_cfg;
    assign res_idx     = c_q.out_idx;
    assign err_timeout = c_q.err;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_sck,
    input logic             adc_sdi,
    input logic             adc_convst,
    input logic             res_valid,
    input logic             res_ready,
    input logic [RES_W-1:0] res_data,
    input logic [7:0]       res_cfg,
    input logic             err_timeout
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!adc_sck && !adc_convst && !res_valid && !err_timeout));

    assert_sdi_moves_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(adc_sdi) |-> !adc_sck);

    assert_sck_high_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_sck) |=> adc_sck);

    assert_convst_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_convst) |=> adc_convst);

    assert_no_sck_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_convst && adc_sck));

    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_cfg)));
endmodule

bind adc_scan_sequencer adc_seq_checker #(.RES_W(RES_W)) u_seq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_sck     (adc_sck),
    .adc_sdi     (adc_sdi),
    .adc_convst  (adc_convst),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_data    (res_data),
    .res_cfg     (res_cfg),
    .err_timeout (err_timeout)
);

// File: tb/adc_scan_sequencer_bench.sv
module adc_scan_sequencer_bench;
    localparam int CLK_P  = 10;
    localparam int RW     = 12;
    localparam int IW     = 3;
    localparam int CONV_T = 20;
    localparam logic [7:0] CFG_TAB [4] = '{8'hA4, 8'h17, 8'hC9, 8'h62};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [IW-1:0] scan_last = 3'd3;
    logic [15:0] busy_limit = 16'd200;
    logic cfg_we = 1'b0;
    logic [IW-1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic adc_sck, adc_sdi, adc_sdo, adc_convst;
    logic adc_busy;
    logic res_valid;
    logic res_ready = 1'b1;
    logic [RW-1:0] res_data;
    logic [7:0] res_cfg;
    logic [IW-1:0] res_idx;
    logic err_timeout;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [7:0] cur [4];

    always #(CLK_P/2) clk = ~clk;

    adc_scan_sequencer u_adc_scan_sequencer (
        .clk(clk), .rst_n(rst_n), .run(run), .scan_last(scan_last),
        .busy_limit(busy_limit), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .adc_sck(adc_sck), .adc_sdi(adc_sdi),
        .adc_sdo(adc_sdo), .adc_convst(adc_convst), .adc_busy(adc_busy),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_cfg(res_cfg), .res_idx(res_idx), .err_timeout(err_timeout)
    );

    function automatic logic [RW-1:0] conv_of(input logic [7:0] c);
        return {c, c[7:4] ^ 4'h5};
    endfunction

    // converter model
    logic hang = 1'b0;
    logic m_sck_p, m_cv_p;
    logic [RW-1:0] m_tx;
    logic [7:0] m_rx, m_cfg;
    int m_bits, m_rises, m_tmr, m_cvw;
    int conv_count, frame_err, cw_err, viol;

    assign adc_sdo = m_tx[RW-1];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sck_p <= 1'b0; m_cv_p <= 1'b0; m_tx <= 12'hBAD; m_rx <= '0;
            m_cfg <= '0; m_bits <= 0; m_rises <= 0; m_tmr <= 0; m_cvw <= 0;
            conv_count <= 0; frame_err <= 0; cw_err <= 0; viol <= 0;
            adc_busy <= 1'b1;
        end else begin
            m_sck_p <= adc_sck;
            m_cv_p  <= adc_convst;
            if (adc_sck && !m_sck_p) begin
                if (m_bits < 8) m_rx <= {m_rx[6:0], adc_sdi};
                m_bits  <= m_bits + 1;
                m_rises <= m_rises + 1;
                if (!adc_busy) viol <= viol + 1;
            end
            if (!adc_sck && m_sck_p) m_tx <= {m_tx[RW-2:0], 1'b0};
            if (adc_convst) m_cvw <= m_cvw + 1;
            if (!adc_convst && m_cv_p) begin
                if (m_cvw != 2) cw_err <= cw_err + 1;
                m_cvw <= 0;
            end
            if (adc_convst && !m_cv_p) begin
                conv_count <= conv_count + 1;
                if (m_rises != RW) frame_err <= frame_err + 1;
                if (!adc_busy) viol <= viol + 1;
                m_rises <= 0;
                m_bits  <= 0;
                if (!hang) begin
                    adc_busy <= 1'b0;
                    m_tmr    <= CONV_T;
                    m_cfg    <= m_rx;
                end
            end else if (!adc_busy) begin
                if (m_tmr == 0) begin
                    adc_busy <= 1'b1;
                    m_tx     <= conv_of(m_cfg);
                end else begin
                    m_tmr <= m_tmr - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_result(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (res_valid) begin
                got = 1'b1;
                break;
            end
        end
        if (!got) chk(1'b0, "R6 result timeout", 0, 1);
    endtask

    task automatic write_entry(input int a, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = IW'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cur[a] = v;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        bit got;
        int cc;
        logic [RW-1:0] held;
        repeat (3) @(negedge clk);
        chk(!adc_sck && !adc_convst, "R1 converter lines in reset", {adc_sck, adc_convst}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!res_valid && !err_timeout, "R1 outputs after reset", {res_valid, err_timeout}, 0);
        chk(!adc_sck && !adc_convst, "R1 lines after reset", {adc_sck, adc_convst}, 0);

        for (int a = 0; a < 4; a++) write_entry(a, CFG_TAB[a]);
        run = 1'b1;

        // table walk: R2 R3 R6 R7 R9
        for (int k = 0; k < 8; k++) begin
            wait_result(got);
            if (got) begin
                chk(res_idx == IW'(k % 4), "R9 scan order", res_idx, k % 4);
                chk(res_cfg == CFG_TAB[k % 4], "R6 tag", res_cfg, CFG_TAB[k % 4]);
                chk(res_data == conv_of(CFG_TAB[k % 4]), "R2 R3 data", res_data,
                    conv_of(CFG_TAB[k % 4]));
                if (k == 0) chk(res_data != 12'hBAD, "R7 stale dropped", res_data, 0);
            end
        end
        chk(frame_err == 0, "R3 edges per frame", frame_err, 0);
        chk(cw_err == 0, "R4 convst width", cw_err, 0);
        chk(viol == 0, "R5 busy respected", viol, 0);

        // R10 back-pressure
        res_ready = 1'b0;
        wait_result(got);
        held = res_data;
        repeat (60) @(negedge clk);
        cc = conv_count;
        repeat (300) @(negedge clk);
        chk(res_valid, "R10 valid held", res_valid, 1);
        chk(res_data == held, "R10 data held", res_data, held);
        chk(conv_count == cc, "R10 no exchange while pending", conv_count, cc);
        res_ready = 1'b1;
        @(negedge clk);

        // R8 list write mid-scan
        write_entry(0, 8'h3C);
        wait_result(got);
        chk(res_idx == 0, "R8 restart index", res_idx, 0);
        chk(res_cfg == 8'h3C, "R8 new word", res_cfg, 8'h3C);
        chk(res_data == conv_of(8'h3C), "R8 new data", res_data, conv_of(8'h3C));

        // R11 timeout
        busy_limit = 16'd60;
        hang = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (err_timeout) break;
        end
        chk(err_timeout, "R11 timeout flagged", err_timeout, 1);
        hang = 1'b0;
        wait_result(got);
        chk(res_cfg == cur[res_idx[1:0]], "R11 tag after timeout", res_cfg, cur[res_idx[1:0]]);
        chk(res_data == conv_of(res_cfg), "R11 data after timeout", res_data, conv_of(res_cfg));
        chk(err_timeout, "R11 flag sticky", err_timeout, 1);
        write_entry(1, cur[1]);
        chk(!err_timeout, "R8 R11 flag cleared by write", err_timeout, 0);

        // R12 run low
        run = 1'b0;
        repeat (300) @(negedge clk);
        cc = conv_count;
        repeat (500) @(negedge clk);
        chk(conv_count == cc, "R12 idle when not running", conv_count, cc);
        chk(!adc_sck, "R12 sck idle", adc_sck, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule